// File: doc/BRIEF.md
# Coprocessor Register Access Permission Checker

This block sits next to the register decode of a coprocessor interface. Each cycle it may receive one register access: opcode_1, CRn, CRm and opcode_2 fields, a bank bit that tells the performance-monitor bank from the system-validation counter bank (both banks use the same primary encoding), and a read/write flag. It also receives the state of the requester: privilege, security world, the user-access validation bit (V) and a lock input that blocks secure privileged writes to the validation counters. From these it decides whether the access moves data, raises an undefined-instruction exception, gives an unpredictable result or has no effect.

The verdict is registered, so it appears one clock after the request. It comes with a one-hot register select and separate write and read enables. Any access that ends in an exception, no effect or an unpredictable result leaves all enables and selects low. The consumer returns zero for an unpredictable read. The register storage itself and the exception handling are outside this block.

Top module: `cpacc_check`

## Requirements
- R1: The response appears one clock after the request, with `rsp_valid` high. In a cycle with no request, and while reset is held, every output is 0.
- R2: In bank 0 (`req_bank`=0), the primary encoding opcode_1=0, CRn=15, CRm=12 with opcode_2 of 0, 1, 2 or 3 selects the control, cycle-count, event-count-0 or event-count-1 register, on `rsp_sel` bits 0 to 3. Opcode_2 of 4 to 7 in bank 0, or any other opcode_1/CRn/CRm in either bank, has no effect: valid only, with every other output 0.
- R3: A performance-monitor access in privileged mode is granted in both security worlds, whatever V and the lock input are.
- R4: A performance-monitor access in user mode raises an undefined exception when V=0 and is granted when V=1.
- R5: In bank 1, with the same primary encoding, opcode_2 of 1, 2 and 3 selects the reset, interrupt and fast-interrupt counters on `rsp_sel` bits 4, 5 and 6. Opcode_2 of 7 selects the debug-request counter on bit 7. Opcode_2 of 0, 4, 5 or 6 has no effect.
- R6: With V=0, a validation-bank access (any of the four counters) is allowed only in secure privileged mode. In non-secure privileged or user mode it raises an undefined exception.
- R7: With V=1, validation-bank accesses are allowed in every mode and world (subject to R9).
- R8: An allowed read of the debug-request counter gives `rsp_unpred`=1, with `rsp_grant`, `rsp_rd_en` and `rsp_undef` all 0; the consumer returns zero. An allowed write to that counter is granted.
- R9: A write to the validation bank in secure privileged mode while `sec_wr_lock`=1 raises an undefined exception, whatever V is. Reads are not affected, and the lock has no effect on the performance-monitor bank.
- R10: A response with `rsp_undef`=1 never has `rsp_grant`, `rsp_wr_en`, `rsp_rd_en` or any `rsp_sel` bit set.
- R11: A granted access sets exactly one `rsp_sel` bit. It sets `rsp_wr_en` for a write and `rsp_rd_en` for a read, never both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_bank | input | 1 | 0: performance-monitor bank, 1: validation-counter bank |
| req_op1 | input | OP1_W | opcode_1 field |
| req_crn | input | CRN_W | CRn field |
| req_crm | input | CRM_W | CRm field |
| req_op2 | input | OP2_W | opcode_2 field |
| req_write | input | 1 | 1: write, 0: read |
| mode_priv | input | 1 | 1: privileged mode, 0: user mode |
| world_secure | input | 1 | 1: secure world, 0: non-secure world |
| user_ok | input | 1 | User-access validation bit (V) |
| sec_wr_lock | input | 1 | Blocks secure privileged writes to the validation bank |
| rsp_valid | output | 1 | A verdict is presented this cycle |
| rsp_grant | output | 1 | The access moves data |
| rsp_undef | output | 1 | Undefined-instruction exception |
| rsp_unpred | output | 1 | Unpredictable read, returns zero |
| rsp_wr_en | output | 1 | Write enable toward the selected register |
| rsp_rd_en | output | 1 | Read enable toward the selected register |
| rsp_sel | output | 8 | One-hot register select |

## Verification
The bench builds the block with its default parameters: opcode_1=0, CRn=15, CRm=12, 3-bit opcode_2 and debug counter at opcode_2=7. With these values random stimulus covers all eight opcode_2 codes in both banks. That includes the unused codes around the validation counters and the codes above the four performance-monitor registers. Random values are weighted toward the primary encoding, so the full set of mode, world, V, lock and direction combinations is reached for every register. A share of misses still exercises the no-effect path.

// File: rtl/cpacc_pkg.sv
package cpacc_pkg;

    localparam int PMU_REGS  = 4;
    localparam int VCNT_REGS = 3;
    localparam int SEL_W     = PMU_REGS + VCNT_REGS + 1;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_PMU  = 2'd1,
        CLS_VCNT = 2'd2,
        CLS_VDBG = 2'd3
    } reg_class_e;

    typedef enum logic [1:0] {
        OUT_NONE   = 2'd0,
        OUT_DATA   = 2'd1,
        OUT_UNDEF  = 2'd2,
        OUT_UNPRED = 2'd3
    } outcome_e;

    typedef struct packed {
        logic             valid;
        logic             grant;
        logic             undef;
        logic             unpred;
        logic             wr_en;
        logic             rd_en;
        logic [SEL_W-1:0] sel;
    } rsp_t;

endpackage

// File: rtl/cpacc_decode.sv
module cpacc_decode
    import cpacc_pkg::*;
#(
    parameter int OP1_W   = 3,
    parameter int CRN_W   = 4,
    parameter int CRM_W   = 4,
    parameter int OP2_W   = 3,
    parameter int GRP_OP1 = 0,
    parameter int GRP_CRN = 15,
    parameter int GRP_CRM = 12,
    parameter int DBG_OP2 = 7
) (
    input  logic             bank,
    input  logic [OP1_W-1:0] op1,
    input  logic [CRN_W-1:0] crn,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output reg_class_e       cls,
    output logic [SEL_W-1:0] sel
);

    logic                 base_hit;
    logic [PMU_REGS-1:0]  pm_hit;
    logic [VCNT_REGS-1:0] vc_hit;
    logic                 dbg_hit;

    assign base_hit = (op1 == OP1_W'(GRP_OP1)) &&
                      (crn == CRN_W'(GRP_CRN)) &&
                      (crm == CRM_W'(GRP_CRM));

    // performance-monitor bank: opcode_2 equals the register index
    for (genvar i = 0; i < PMU_REGS; i++) begin : g_pm
        assign pm_hit[i] = base_hit && !bank && (op2 == OP2_W'(i));
    end

    // validation bank: counters start at opcode_2 = 1
    for (genvar i = 0; i < VCNT_REGS; i++) begin : g_vc
        assign vc_hit[i] = base_hit && bank && (op2 == OP2_W'(i + 1));
    end

    assign dbg_hit = base_hit && bank && (op2 == OP2_W'(DBG_OP2));

    assign sel = {dbg_hit, vc_hit, pm_hit};

    always_comb begin
        if (|pm_hit)      cls = CLS_PMU;
        else if (|vc_hit) cls = CLS_VCNT;
        else if (dbg_hit) cls = CLS_VDBG;
        else              cls = CLS_NONE;
    end

endmodule

// File: rtl/cpacc_perm.sv
module cpacc_perm
    import cpacc_pkg::*;
(
    input  reg_class_e cls,
    input  logic       is_write,
    input  logic       priv,
    input  logic       secure,
    input  logic       v_bit,
    input  logic       wr_lock,
    output outcome_e   outcome
);

    logic sec_priv;
    logic locked_wr;
    logic val_allowed;

    assign sec_priv    = priv && secure;
    assign locked_wr   = sec_priv && is_write && wr_lock;
    assign val_allowed = sec_priv || v_bit;

    always_comb begin
        outcome = OUT_NONE;
        case (cls)
            CLS_PMU: begin
                outcome = (priv || v_bit) ? OUT_DATA : OUT_UNDEF;
            end
            CLS_VCNT: begin
                if (locked_wr)        outcome = OUT_UNDEF;
                else if (val_allowed) outcome = OUT_DATA;
                else                  outcome = OUT_UNDEF;
            end
            CLS_VDBG: begin
                if (locked_wr)         outcome = OUT_UNDEF;
                else if (!val_allowed) outcome = OUT_UNDEF;
                else if (is_write)     outcome = OUT_DATA;
                else                   outcome = OUT_UNPRED;
            end
            default: outcome = OUT_NONE;
        endcase
    end

endmodule

// File: rtl/cpacc_check.sv
module cpacc_check
    import cpacc_pkg::*;
#(
    parameter int OP1_W   = 3,
    parameter int CRN_W   = 4,
    parameter int CRM_W   = 4,
    parameter int OP2_W   = 3,
    parameter int GRP_OP1 = 0,
    parameter int GRP_CRN = 15,
    parameter int GRP_CRM = 12,
    parameter int DBG_OP2 = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_bank,
    input  logic [OP1_W-1:0] req_op1,
    input  logic [CRN_W-1:0] req_crn,
    input  logic [CRM_W-1:0] req_crm,
    input  logic [OP2_W-1:0] req_op2,
    input  logic             req_write,
    input  logic             mode_priv,
    input  logic             world_secure,
    input  logic             user_ok,
    input  logic             sec_wr_lock,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic             rsp_undef,
    output logic             rsp_unpred,
    output logic             rsp_wr_en,
    output logic             rsp_rd_en,
    output logic [SEL_W-1:0] rsp_sel
);

    reg_class_e       dec_cls;
    logic [SEL_W-1:0] dec_sel;
    outcome_e         verdict;
    rsp_t             rsp_d;
    rsp_t             rsp_q;

    cpacc_decode #(
        .OP1_W  (OP1_W),
        .CRN_W  (CRN_W),
        .CRM_W  (CRM_W),
        .OP2_W  (OP2_W),
        .GRP_OP1(GRP_OP1),
        .GRP_CRN(GRP_CRN),
        .GRP_CRM(GRP_CRM),
        .DBG_OP2(DBG_OP2)
    ) u_decode (
        .bank(req_bank),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .cls (dec_cls),
        .sel (dec_sel)
    );

    cpacc_perm u_perm (
        .cls     (dec_cls),
        .is_write(req_write),
        .priv    (mode_priv),
        .secure  (world_secure),
        .v_bit   (user_ok),
        .wr_lock (sec_wr_lock),
        .outcome (verdict)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            case (verdict)
                OUT_DATA: begin
                    rsp_d.grant = 1'b1;
                    rsp_d.wr_en = req_write;
                    rsp_d.rd_en = !req_write;
                    rsp_d.sel   = dec_sel;
                end
                OUT_UNDEF:  rsp_d.undef  = 1'b1;
                OUT_UNPRED: rsp_d.unpred = 1'b1;
                default:    rsp_d        = rsp_d;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_grant  = rsp_q.grant;
    assign rsp_undef  = rsp_q.undef;
    assign rsp_unpred = rsp_q.unpred;
    assign rsp_wr_en  = rsp_q.wr_en;
    assign rsp_rd_en  = rsp_q.rd_en;
    assign rsp_sel    = rsp_q.sel;

    // ---- assertion support, taken straight from the ports ----
    logic a_base, a_pm, a_vc, a_dbg, a_val, a_sp;
    assign a_base = (req_op1 == OP1_W'(GRP_OP1)) && (req_crn == CRN_W'(GRP_CRN)) &&
                    (req_crm == CRM_W'(GRP_CRM));
    assign a_pm   = a_base && !req_bank && (req_op2 < OP2_W'(PMU_REGS));
    assign a_vc   = a_base && req_bank && (req_op2 >= OP2_W'(1)) &&
                    (req_op2 <= OP2_W'(VCNT_REGS));
    assign a_dbg  = a_base && req_bank && (req_op2 == OP2_W'(DBG_OP2));
    assign a_val  = a_vc || a_dbg;
    assign a_sp   = mode_priv && world_secure;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_grant && !rsp_undef && !rsp_unpred && rsp_sel == '0)); // R1
    AST_MISS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !a_pm && !a_val) |=> (rsp_valid && !rsp_grant && !rsp_undef && !rsp_unpred)); // R2
    AST_PMU_PRIV_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_pm && mode_priv) |=> rsp_grant); // R3
    AST_PMU_USER_V0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_pm && !mode_priv && !user_ok) |=> rsp_undef); // R4
    AST_VAL_V0_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_val && !user_ok && !a_sp) |=> rsp_undef); // R6
    AST_VAL_V1_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_vc && user_ok && !(a_sp && req_write && sec_wr_lock)) |=> rsp_grant); // R7
    AST_DBG_RD_UNPRED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_dbg && !req_write && (user_ok || a_sp)) |=>
        (rsp_unpred && !rsp_rd_en && !rsp_undef && !rsp_grant)); // R8
    AST_LOCK_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_val && a_sp && req_write && sec_wr_lock) |=> rsp_undef); // R9
    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_undef |-> (!rsp_grant && !rsp_wr_en && !rsp_rd_en && rsp_sel == '0)); // R10
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_sel)); // R11
    AST_GRANT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> ((rsp_wr_en ^ rsp_rd_en) && $countones(rsp_sel) == 1)); // R11

endmodule

// File: tb/cpacc_check_tb.sv
`timescale 1ns/1ps
module cpacc_check_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_bank = 1'b0, req_write = 1'b0;
    logic [2:0] req_op1 = '0, req_op2 = '0;
    logic [3:0] req_crn = '0, req_crm = '0;
    logic       mode_priv = 1'b0, world_secure = 1'b0, user_ok = 1'b0, sec_wr_lock = 1'b0;
    logic       rsp_valid, rsp_grant, rsp_undef, rsp_unpred, rsp_wr_en, rsp_rd_en;
    logic [7:0] rsp_sel;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    cpacc_check u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
        .req_write(req_write), .mode_priv(mode_priv), .world_secure(world_secure),
        .user_ok(user_ok), .sec_wr_lock(sec_wr_lock), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_undef(rsp_undef), .rsp_unpred(rsp_unpred),
        .rsp_wr_en(rsp_wr_en), .rsp_rd_en(rsp_rd_en), .rsp_sel(rsp_sel)
    );

    // expected {valid, grant, undef, unpred, wr_en, rd_en, sel[7:0]}
    function automatic logic [13:0] expect_rsp(logic v, logic bank, logic [2:0] op1,
            logic [3:0] crn, logic [3:0] crm, logic [2:0] op2, logic wr,
            logic priv, logic sec, logic vb, logic lock);
        logic       hit, pm, vc, dbg, sp, ok;
        logic [7:0] sel;
        if (!v) return '0;
        hit = (op1 == 3'd0) && (crn == 4'd15) && (crm == 4'd12);
        pm  = hit && !bank && (op2 <= 3'd3);
        vc  = hit && bank && (op2 >= 3'd1) && (op2 <= 3'd3);
        dbg = hit && bank && (op2 == 3'd7);
        sp  = priv && sec;
        if (pm)       sel = 8'(1) << op2;
        else if (vc)  sel = 8'(1) << (op2 + 3'd3);
        else          sel = 8'h80;
        if (!(pm || vc || dbg)) return {1'b1, 13'b0};
        if (pm) begin
            ok = priv || vb;
            return ok ? {2'b11, 2'b00, wr, !wr, sel} : {3'b101, 11'b0};
        end
        if (sp && wr && lock) return {3'b101, 11'b0};
        ok = sp || vb;
        if (!ok) return {3'b101, 11'b0};
        if (dbg && !wr) return {4'b1001, 10'b0};
        return {2'b11, 2'b00, wr, !wr, sel};
    endfunction

    function automatic string tag_of(logic bank, logic [2:0] op1, logic [3:0] crn,
            logic [3:0] crm, logic [2:0] op2, logic wr, logic priv, logic sec,
            logic vb, logic lock, logic [13:0] e);
        logic hit;
        string t;
        hit = (op1 == 3'd0) && (crn == 4'd15) && (crm == 4'd12);
        if (!hit || (!bank && op2 > 3'd3)) t = "R2";
        else if (bank && (op2 == 3'd0 || (op2 >= 3'd4 && op2 <= 3'd6))) t = "R5";
        else if (!bank) t = priv ? "R3" : "R4";
        else if (priv && sec && wr && lock) t = "R9";
        else if (e[10]) t = "R8";
        else if (vb) t = "R7";
        else t = "R6";
        if (e[11]) t = {t, "+R10"};
        if (e[12]) t = {t, "+R11"};
        return t;
    endfunction

    function automatic logic [13:0] actual_rsp();
        return {rsp_valid, rsp_grant, rsp_undef, rsp_unpred, rsp_wr_en, rsp_rd_en, rsp_sel};
    endfunction

    task automatic check(string tag, logic [13:0] exp_v);
        n_checks++;
        if (actual_rsp() !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual=%014b expected=%014b", tag, actual_rsp(), exp_v);
        end
    endtask

    // called at a falling edge; drives, waits one cycle, checks at the next falling edge
    task automatic access(logic v, logic bank, logic [2:0] op1, logic [3:0] crn,
            logic [3:0] crm, logic [2:0] op2, logic wr, logic priv, logic sec,
            logic vb, logic lock, string tag);
        logic [13:0] e;
        req_valid = v; req_bank = bank; req_op1 = op1; req_crn = crn; req_crm = crm;
        req_op2 = op2; req_write = wr; mode_priv = priv; world_secure = sec;
        user_ok = vb; sec_wr_lock = lock;
        e = expect_rsp(v, bank, op1, crn, crm, op2, wr, priv, sec, vb, lock);
        @(negedge clk);
        if (tag == "") tag = v ? tag_of(bank, op1, crn, crm, op2, wr, priv, sec, vb, lock, e) : "R1";
        check(tag, e);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        check("R1 reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        access(0, 0, 0, 15, 12, 0, 0, 1, 1, 1, 0, "R1 idle");
        // R2 / R3 / R4 directed
        access(1, 0, 0, 15, 12, 0, 1, 1, 0, 0, 1, "R3 ctrl write nonsecure priv");
        access(1, 0, 0, 15, 12, 3, 0, 1, 1, 0, 0, "R3 count1 read secure priv");
        access(1, 0, 0, 15, 12, 1, 0, 0, 1, 0, 0, "R4 user V0 undef, R10");
        access(1, 0, 0, 15, 12, 2, 1, 0, 0, 1, 0, "R4 user V1 grant, R11");
        access(1, 0, 0, 15, 12, 5, 0, 1, 1, 1, 0, "R2 op2 beyond pmu");
        access(1, 0, 1, 15, 12, 0, 0, 1, 1, 1, 0, "R2 wrong op1");
        access(1, 1, 0, 15, 11, 1, 0, 1, 1, 1, 0, "R2 wrong crm");
        // R5 / R6 / R7 / R8 / R9 directed
        access(1, 1, 0, 15, 12, 0, 0, 1, 1, 1, 0, "R5 op2 0 no effect");
        access(1, 1, 0, 15, 12, 6, 1, 1, 1, 1, 0, "R5 op2 6 no effect");
        access(1, 1, 0, 15, 12, 1, 1, 1, 1, 0, 0, "R6 secure priv V0 grant");
        access(1, 1, 0, 15, 12, 2, 0, 1, 0, 0, 0, "R6 nonsecure priv V0 undef");
        access(1, 1, 0, 15, 12, 7, 1, 0, 1, 0, 0, "R6 debug write user V0 undef");
        access(1, 1, 0, 15, 12, 3, 0, 0, 0, 1, 0, "R7 user V1 grant");
        access(1, 1, 0, 15, 12, 7, 0, 1, 1, 0, 0, "R8 debug read unpredictable");
        access(1, 1, 0, 15, 12, 7, 1, 0, 0, 1, 0, "R8 debug write granted");
        access(1, 1, 0, 15, 12, 1, 1, 1, 1, 1, 1, "R9 locked write V1");
        access(1, 1, 0, 15, 12, 7, 1, 1, 1, 0, 1, "R9 locked debug write");
        access(1, 1, 0, 15, 12, 2, 0, 1, 1, 0, 1, "R9 lock ignores reads");
        access(1, 0, 0, 15, 12, 1, 1, 1, 1, 0, 1, "R9 lock ignores pmu bank");
        access(0, 1, 0, 15, 12, 1, 1, 1, 1, 1, 0, "R1 idle after traffic");
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic near;
            logic [2:0] op1;
            logic [3:0] crn, crm;
            near = ($urandom % 8) != 0;
            op1 = near ? 3'd0 : 3'($urandom);
            crn = near ? 4'd15 : 4'($urandom);
            crm = near ? 4'd12 : 4'($urandom);
            access(($urandom % 10) != 0, 1'($urandom), op1, crn, crm, 3'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "");
        end
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule